// File: doc/BRIEF.md
# Glitch-Free Multi-Phase Edge Waveform Generator

This block produces seven single-bit timing waveforms from one free-running binary counter whose period is exactly 256 clocks. Four of the waveforms ("leading" group) start each period low and rise on successive counts near the start. The other three ("trailing" group) start each period high and fall on successive counts near the end. Downstream logic uses them as phase-staggered enables or strobes that must never glitch.

No output is a combinational decode of the counter. Each waveform is a set/clear flip-flop. A few shared count decodes drive these flip-flops. Within each group, every waveform after the first is chained from its neighbour, one clock later, so no output needs its own full comparator. A synchronous reset preloads the counter to its terminal value and the waveforms to their count-0 levels. A count enable freezes the whole block.

Top module: `phase_edge_gen`

## Requirements
- R1: With `enable` high and `rst` low, `count` increases by one per clock and wraps from 255 to 0, so the period is exactly 256 enabled clocks.
- R2: Leading bits `waveOut[0]`, `waveOut[1]`, `waveOut[2]` and `waveOut[3]` are low while `count` is below 5, 4, 3 and 2 respectively, and high for all higher counts.
- R3: Trailing bits `waveOut[4]`, `waveOut[5]` and `waveOut[6]` are high while `count` is at most 251, 252 and 253 respectively, and low for all higher counts.
- R4: Each of `waveOut[2]`, `waveOut[1]` and `waveOut[0]` rises only on a clock where the next higher leading bit was already high in the previous cycle.
- R5: Each of `waveOut[5]` and `waveOut[6]` falls only on a clock where the next lower trailing bit was already low in the previous cycle.
- R6: While `rst` is high, and on the clock after it is released, `count` reads 255, `waveOut[3:0]` reads 0 and `waveOut[6:4]` reads all ones. The first enabled clock then enters count 0 with the waveforms correct for the whole period.
- R7: While `enable` is low, `count` and all of `waveOut` keep their values. This includes a stall on count 127, ahead of the 127 to 128 carry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high, overrides `enable` |
| enable | input | 1 | Count enable; low freezes counter and waveforms |
| waveOut | output | 7 | Registered waveforms; bits 3:0 leading group, bits 6:4 trailing group |
| count | output | 8 | Current counter value |

## Verification
The bench builds the block with its default parameters. These are an 8-bit counter, four leading and three trailing waveforms, the leading set decode at count 1 and the trailing clear decode at count 251. With these values every waveform edge and the counter wrap occur within a few hundred clocks, so several full periods fit in a short run. A stall parked on count 127 exercises the carry into the top bit. Resets are applied in the middle of a period and with the enable low, which exercises the preload values and the first period after reset.

// File: rtl/phase_edge_pkg.sv
package phase_edge_pkg;

  // Strobes from the decode control to the waveform datapath.
  typedef struct packed {
    logic advance;   // counter and chains may move this clock
    logic leadClr;   // terminal count: leading group returns low
    logic leadSet;   // first leading waveform rises
    logic trailSet;  // terminal count: trailing group returns high
    logic trailClr;  // first trailing waveform falls
  } edgeStrobes_t;

endpackage

// File: rtl/phase_edge_counter.sv
module phase_edge_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             advance,
  output logic [CNT_W-1:0] count
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= CNT_MAX;
    end else if (advance) begin
      count <= count + CNT_ONE;
    end
  end

endmodule

// File: rtl/phase_edge_ctrl.sv
module phase_edge_ctrl
  import phase_edge_pkg::*;
#(
  parameter int CNT_W        = 8,
  parameter int LEAD_SET_AT  = 1,
  parameter int TRAIL_CLR_AT = 251
) (
  input  logic [CNT_W-1:0] count,
  input  logic             enable,
  output edgeStrobes_t     strobes
);

  localparam logic [CNT_W-1:0] CNT_MAX  = '1;
  localparam logic [CNT_W-1:0] LEAD_PT  = CNT_W'(LEAD_SET_AT);
  localparam logic [CNT_W-1:0] TRAIL_PT = CNT_W'(TRAIL_CLR_AT);

  logic wrapHit;
  logic leadHit;
  logic trailHit;

  // Three decodes in total, shared by all seven waveforms.
  always_comb begin
    wrapHit  = (count == CNT_MAX);
    leadHit  = (count == LEAD_PT);
    trailHit = (count == TRAIL_PT);
  end

  always_comb begin
    strobes.advance  = enable;
    strobes.leadClr  = enable & wrapHit;
    strobes.trailSet = enable & wrapHit;
    strobes.leadSet  = enable & leadHit;
    strobes.trailClr = enable & trailHit;
  end

endmodule

// File: rtl/phase_edge_bank.sv
module phase_edge_bank
  import phase_edge_pkg::*;
#(
  parameter int LEAD_N  = 4,
  parameter int TRAIL_N = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  edgeStrobes_t       strobes,
  output logic [LEAD_N-1:0]  leadQ,
  output logic [TRAIL_N-1:0] trailQ
);

  logic [LEAD_N-1:0]  leadNext;
  logic [TRAIL_N-1:0] trailNext;

  // Leading group: clear wins over set; the top bit is set by decode,
  // each lower bit is set once its upper neighbour is high.
  for (genvar i = 0; i < LEAD_N; i++) begin : g_lead
    logic setCond;
    if (i == LEAD_N - 1) begin : g_head
      always_comb setCond = strobes.leadSet;
    end else begin : g_link
      always_comb setCond = strobes.advance & leadQ[i+1];
    end
    always_comb begin
      if (strobes.leadClr)  leadNext[i] = 1'b0;
      else if (setCond)     leadNext[i] = 1'b1;
      else                  leadNext[i] = leadQ[i];
    end
  end

  // Trailing group: set wins over clear; bit 0 is cleared by decode,
  // each higher bit is cleared once its lower neighbour is low.
  for (genvar j = 0; j < TRAIL_N; j++) begin : g_trail
    logic clrCond;
    if (j == 0) begin : g_head
      always_comb clrCond = strobes.trailClr;
    end else begin : g_link
      always_comb clrCond = strobes.advance & ~trailQ[j-1];
    end
    always_comb begin
      if (strobes.trailSet) trailNext[j] = 1'b1;
      else if (clrCond)     trailNext[j] = 1'b0;
      else                  trailNext[j] = trailQ[j];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      leadQ  <= '0;
      trailQ <= '1;
    end else begin
      leadQ  <= leadNext;
      trailQ <= trailNext;
    end
  end

endmodule

// File: rtl/phase_edge_gen.sv
module phase_edge_gen
  import phase_edge_pkg::*;
#(
  parameter int CNT_W        = 8,
  parameter int LEAD_N       = 4,
  parameter int TRAIL_N      = 3,
  parameter int LEAD_SET_AT  = 1,
  parameter int TRAIL_CLR_AT = 251,
  localparam int NUM_W       = LEAD_N + TRAIL_N
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  output logic [NUM_W-1:0] waveOut,
  output logic [CNT_W-1:0] count
);

  edgeStrobes_t       strobes;
  logic [LEAD_N-1:0]  leadQ;
  logic [TRAIL_N-1:0] trailQ;

  phase_edge_ctrl #(
    .CNT_W       (CNT_W),
    .LEAD_SET_AT (LEAD_SET_AT),
    .TRAIL_CLR_AT(TRAIL_CLR_AT)
  ) u_ctrl (
    .count  (count),
    .enable (enable),
    .strobes(strobes)
  );

  phase_edge_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk    (clk),
    .rst    (rst),
    .advance(strobes.advance),
    .count  (count)
  );

  phase_edge_bank #(.LEAD_N(LEAD_N), .TRAIL_N(TRAIL_N)) u_bank (
    .clk    (clk),
    .rst    (rst),
    .strobes(strobes),
    .leadQ  (leadQ),
    .trailQ (trailQ)
  );

  assign waveOut = {trailQ, leadQ};

endmodule

// File: rtl/phase_edge_chk.sv
module phase_edge_chk #(
  parameter int CNT_W   = 8,
  parameter int LEAD_N  = 4,
  parameter int TRAIL_N = 3,
  localparam int NUM_W  = LEAD_N + TRAIL_N
) (
  input logic             clk,
  input logic             rst,
  input logic             enable,
  input logic [NUM_W-1:0] waveOut,
  input logic [CNT_W-1:0] count
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  assert_count_step_R1: assert property (@(posedge clk) disable iff (rst)
    enable |=> count == CNT_W'($past(count) + CNT_W'(1)));

  assert_lead_low_at_zero_R2: assert property (@(posedge clk) disable iff (rst)
    (count == '0) |-> (waveOut[LEAD_N-1:0] == '0));

  assert_trail_high_at_zero_R3: assert property (@(posedge clk) disable iff (rst)
    (count == '0) |-> (&waveOut[NUM_W-1:LEAD_N]));

  for (genvar i = 0; i < LEAD_N - 1; i++) begin : g_lead_chain
    assert_lead_chain_R4: assert property (@(posedge clk) disable iff (rst)
      $rose(waveOut[i]) |-> $past(waveOut[i+1]));
  end

  for (genvar j = 1; j < TRAIL_N; j++) begin : g_trail_chain
    assert_trail_chain_R5: assert property (@(posedge clk) disable iff (rst)
      $fell(waveOut[LEAD_N+j]) |-> !$past(waveOut[LEAD_N+j-1]));
  end

  assert_reset_load_R6: assert property (@(posedge clk)
    rst |=> (count == CNT_MAX) && (waveOut[LEAD_N-1:0] == '0)
            && (&waveOut[NUM_W-1:LEAD_N]));

  assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !enable |=> $stable(count) && $stable(waveOut));

endmodule

bind phase_edge_gen phase_edge_chk #(
  .CNT_W  (CNT_W),
  .LEAD_N (LEAD_N),
  .TRAIL_N(TRAIL_N)
) u_chk (
  .clk    (clk),
  .rst    (rst),
  .enable (enable),
  .waveOut(waveOut),
  .count  (count)
);

// File: tb/sim_phase_edge_gen.sv
module sim_phase_edge_gen;

  logic       clk = 1'b0;
  logic       rst;
  logic       enable;
  logic [6:0] waveOut;
  logic [7:0] count;

  int vecCount  = 0;
  int failCount = 0;

  // bench reference state
  logic [7:0] expCnt  = 8'hFF;
  logic       armed   = 1'b0;
  logic       lastEn  = 1'b1;
  logic       lastRst = 1'b1;
  logic       started = 1'b0;
  logic [6:0] prevW   = 7'b1110000;

  phase_edge_gen u0 (
    .clk    (clk),
    .rst    (rst),
    .enable (enable),
    .waveOut(waveOut),
    .count  (count)
  );

  always #2 clk = ~clk;

  // Expected waveforms for a count, straight from R2 and R3.
  function automatic logic [6:0] refWave(input logic [7:0] c);
    logic [6:0] r;
    for (int i = 0; i < 4; i++) r[i] = (int'(c) >= 5 - i);
    for (int j = 0; j < 3; j++) r[4+j] = (int'(c) <= 251 + j);
    return r;
  endfunction

  task automatic check(input logic ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
    vecCount++;
    if (!ok) begin
      failCount++;
      $display("FAIL %s: actual %0h expected %0h (t=%0t)", tag, act, exp, $time);
    end
  endtask

  // reference model, advanced on the same edge as the design
  always @(posedge clk) begin
    started <= 1'b1;
    lastEn  <= enable;
    lastRst <= rst;
    if (rst) begin
      expCnt <= 8'hFF;
      armed  <= 1'b0;
    end else if (enable) begin
      expCnt <= expCnt + 8'd1;
      if (expCnt == 8'hFF) armed <= 1'b1;
    end
  end

  // all comparisons on the falling edge
  always @(negedge clk) begin
    if (started) begin
      logic [6:0] expW;
      string cTag, lTag, tTag;
      expW = armed ? refWave(expCnt) : refWave(8'd0);
      cTag = lastRst ? "R6" : (lastEn ? "R1" : "R7");
      lTag = lastRst ? "R6" : (lastEn ? "R2" : "R7");
      tTag = lastRst ? "R6" : (lastEn ? "R3" : "R7");
      check(count == expCnt, cTag, 32'(count), 32'(expCnt));
      check(waveOut[3:0] == expW[3:0], lTag, 32'(waveOut[3:0]), 32'(expW[3:0]));
      check(waveOut[6:4] == expW[6:4], tTag, 32'(waveOut[6:4]), 32'(expW[6:4]));
      if (!lastRst) begin
        for (int i = 0; i < 3; i++)
          if (waveOut[i] && !prevW[i])
            check(prevW[i+1], "R4", 32'(prevW), 32'(prevW | (7'd1 << (i + 1))));
        for (int j = 1; j < 3; j++)
          if (!waveOut[4+j] && prevW[4+j])
            check(!prevW[3+j], "R5", 32'(prevW), 32'(prevW & ~(7'd1 << (3 + j))));
      end
      prevW = waveOut;
    end
  end

  task automatic step(input logic en, input logic r);
    enable = en;
    rst    = r;
    @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'd20250211));
    rst = 1'b1;
    enable = 1'b1;
    // R6: reset held, then plain counting through several periods (R1, R2, R3)
    repeat (4) step(1'b1, 1'b1);
    repeat (700) step(1'b1, 1'b0);
    // R7: stall parked on count 127, then cross into 128
    while (expCnt != 8'd127) step(1'b1, 1'b0);
    repeat (6) step(1'b0, 1'b0);
    repeat (20) step(1'b1, 1'b0);
    // stall exactly on terminal count and on edge counts
    while (expCnt != 8'd255) step(1'b1, 1'b0);
    repeat (3) step(1'b0, 1'b0);
    repeat (5) step(1'b1, 1'b0);
    // random enable pattern
    repeat (1500) step(($urandom % 4) != 0, 1'b0);
    // R6: reset in the middle of a period
    while (expCnt != 8'd200) step(1'b1, 1'b0);
    repeat (2) step(1'($urandom % 2), 1'b1);
    repeat (800) step(1'b1, 1'b0);
    // R6 with R7: reset released while enable stays low
    repeat (2) step(1'b0, 1'b1);
    repeat (4) step(1'b0, 1'b0);
    repeat (300) step(1'b1, 1'b0);
    $display("== %0d vectors applied, %0d miscompares ==", vecCount, failCount);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    failCount++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", vecCount, failCount);
    $finish;
  end

endmodule